// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block holds the time of day and the calendar date as packed-BCD bytes and advances them by one second on each pulse of a one-second tick input. Seconds carry into minutes, minutes into hours, hours into the day of month. The day of month follows the length of the current month, including the leap-year February. The month carries into a two-digit year, and a century bit toggles when the year rolls over. A weekday counter advances alongside the day of month.

A host reaches the nine byte registers through a simple synchronous register bus: one write strobe with address and data, and a read port that returns the addressed byte one cycle later. Setting a stop bit freezes the whole calendar so a new time can be loaded without a carry corrupting it. A validity flag in the seconds byte reports that the stored time cannot be trusted until software writes the seconds register. The one-second tick comes from a prescaler outside this block.

Top module: `bcd_cal_core`

## Requirements
- R1: The registers sit at addresses 0 (control A), 1 (control B), 2 (seconds), 3 (minutes), 4 (hours), 5 (day of month), 6 (weekday), 7 (month) and 8 (year). `rdata` shows the byte at the address sampled on the previous clock edge. Any other address reads 0x00.
- R2: Only the valid bits are stored: seconds and minutes bits 6:0, hours and day bits 5:0, weekday bits 2:0, month bits 4:0 plus the century bit 7, and the full year byte. All other bits read 0. In control A only bit 5 is stored, so writing 0xFF reads back 0x20.
- R3: Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours run from 00 to 23, and the wrap to 00 carries into the day.
- R4: The day of month wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in months 01, 03, 05, 07, 08, 10 and 12. The wrap carries into the month.
- R5: February wraps after day 29 when the two-digit year value is divisible by 4, and after day 28 otherwise.
- R6: The weekday (bits 2:0 of address 6, values 0 to 6) advances by one, modulo 7, on every day carry.
- R7: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00 and inverts the century bit (bit 7 of address 7).
- R8: The invalid-time flag (bit 7 of address 2) is 1 after reset. It clears when the seconds register is written. Writes to any other register leave it unchanged.
- R9: While bit 5 of control A is 1, ticks change no calendar field.
- R10: After bit 5 of control A is written from 1 to 0, the first tick is discarded and the second tick advances the seconds.
- R11: When a write to addresses 2 to 8 lands in the same cycle as a tick, the written value is stored and no field advances for that tick.
- R12: After reset the calendar reads 00:00:00, day 01, weekday 0, month 01, year 00 with the century bit 0, and both control bytes read 0x00.
- R13: Control B is an 8-bit read/write byte that reads back what was last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for the read and write ports |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for the previously sampled address |

## Verification
The bench goes after the carry chain at its end points. These are the last second of the last day of year 99, month ends of 30 and 31 days, and February 28 in both a leap and a common year. A wrong month-length or leap decode would show up as a day 31 in April, a missing February 29, or a February 29 in a common year. A broken century toggle would leave bit 7 of the month unchanged. The stop release is checked tick by tick: a design that skips the discard would advance one second early, and one that ignored stop would drift while a new time is being loaded. Seeded random start times, biased toward 59 seconds, 59 minutes, 23 hours and the last day of the month, followed by runs of ticks, catch carry errors that only appear in combination.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef struct packed {
    logic       cent;
    logic [7:0] year;
    logic [4:0] mon;
    logic [2:0] wday;
    logic [5:0] day;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } cal_t;

  localparam cal_t CAL_RESET = '{cent: 1'b0, year: 8'h00, mon: 5'h01, wday: 3'd0,
                                 day: 6'h01, hour: 6'h00, min: 7'h00, sec: 7'h00};

  // Packed-BCD increment of a two-digit value, no range wrap.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

endpackage

// File: rtl/cal_month_len.sv
module cal_month_len (
  input  logic [4:0] mon,
  input  logic [7:0] year,
  output logic [5:0] last_day
);
  logic [7:0] ybin;
  logic       leap;

  always_comb begin
    ybin = {4'd0, year[7:4]} * 8'd10 + {4'd0, year[3:0]};
    leap = (ybin % 8'd4) == 8'd0;
    case (mon)
      5'h02:                      last_day = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
      default:                    last_day = 6'h31;
    endcase
  end
endmodule

// File: rtl/cal_advance.sv
module cal_advance
  import cal_pkg::*;
(
  input  cal_t cur,
  input  logic step,
  output cal_t nxt
);
  logic [5:0] last_day;
  logic c_sec, c_min, c_hour, c_day, c_mon, c_year;

  cal_month_len u_mlen (
    .mon      (cur.mon),
    .year     (cur.year),
    .last_day (last_day)
  );

  always_comb begin
    c_sec  = cur.sec  == 7'h59;
    c_min  = c_sec  && (cur.min  == 7'h59);
    c_hour = c_min  && (cur.hour == 6'h23);
    c_day  = c_hour && (cur.day  >= last_day);
    c_mon  = c_day  && (cur.mon  == 5'h12);
    c_year = c_mon  && (cur.year == 8'h99);

    nxt = cur;
    if (step) begin
      nxt.sec = c_sec ? 7'h00 : 7'(bcd_inc({1'b0, cur.sec}));
      if (c_sec)  nxt.min  = c_min  ? 7'h00 : 7'(bcd_inc({1'b0, cur.min}));
      if (c_min)  nxt.hour = c_hour ? 6'h00 : 6'(bcd_inc({2'b0, cur.hour}));
      if (c_hour) begin
        nxt.day  = c_day ? 6'h01 : 6'(bcd_inc({2'b0, cur.day}));
        nxt.wday = (cur.wday >= 3'd6) ? 3'd0 : cur.wday + 3'd1;
      end
      if (c_day)  nxt.mon  = c_mon  ? 5'h01 : 5'(bcd_inc({3'b0, cur.mon}));
      if (c_mon)  nxt.year = c_year ? 8'h00 : bcd_inc(cur.year);
      nxt.cent = cur.cent ^ c_year;
    end
  end
endmodule

// File: rtl/cal_rd_mux.sv
module cal_rd_mux
  import cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  cal_t              cal,
  input  logic              vl,
  input  logic              stop,
  input  logic [7:0]        ctl_b,
  output logic [7:0]        data
);
  always_comb begin
    case (addr)
      ADDR_W'(0): data = {2'b00, stop, 5'b00000};
      ADDR_W'(1): data = ctl_b;
      ADDR_W'(2): data = {vl, cal.sec};
      ADDR_W'(3): data = {1'b0, cal.min};
      ADDR_W'(4): data = {2'b00, cal.hour};
      ADDR_W'(5): data = {2'b00, cal.day};
      ADDR_W'(6): data = {5'b00000, cal.wday};
      ADDR_W'(7): data = {cal.cent, 2'b00, cal.mon};
      ADDR_W'(8): data = cal.year;
      default:    data = 8'h00;
    endcase
  end
endmodule

// File: rtl/bcd_cal_core.sv
module bcd_cal_core
  import cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam logic [ADDR_W-1:0] A_CTLA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTLB = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_DAY  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_WDAY = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_YEAR = ADDR_W'(8);
  localparam int               STOP_BIT = 5;

  cal_t       cal_q, cal_nxt;
  logic       vl_q, stop_q, swallow_q;
  logic [7:0] ctl_b_q, rd_comb;
  logic       time_wr, step;

  assign time_wr = wr_en && (addr >= A_SEC) && (addr <= A_YEAR);
  assign step    = tick && !stop_q && !swallow_q && !time_wr;

  cal_advance u_adv (
    .cur  (cal_q),
    .step (step),
    .nxt  (cal_nxt)
  );

  cal_rd_mux #(.ADDR_W(ADDR_W)) u_rd (
    .addr  (addr),
    .cal   (cal_q),
    .vl    (vl_q),
    .stop  (stop_q),
    .ctl_b (ctl_b_q),
    .data  (rd_comb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_q     <= CAL_RESET;
      vl_q      <= 1'b1;
      stop_q    <= 1'b0;
      swallow_q <= 1'b0;
      ctl_b_q   <= 8'h00;
      rdata     <= 8'h00;
    end else begin
      rdata <= rd_comb;
      cal_q <= cal_nxt;
      if (tick && !stop_q) swallow_q <= 1'b0;
      if (wr_en) begin
        case (addr)
          A_CTLA: begin
            stop_q <= wdata[STOP_BIT];
            if (stop_q && !wdata[STOP_BIT]) swallow_q <= 1'b1;
          end
          A_CTLB: ctl_b_q <= wdata;
          A_SEC: begin
            cal_q.sec <= wdata[6:0];
            vl_q      <= 1'b0;
          end
          A_MIN:  cal_q.min  <= wdata[6:0];
          A_HOUR: cal_q.hour <= wdata[5:0];
          A_DAY:  cal_q.day  <= wdata[5:0];
          A_WDAY: cal_q.wday <= wdata[2:0];
          A_MON: begin
            cal_q.mon  <= wdata[4:0];
            cal_q.cent <= wdata[7];
          end
          A_YEAR: cal_q.year <= wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cal_core_chk.sv
module cal_core_chk
  import cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [6:0]        wd_low,
  input cal_t              cal_q,
  input logic              vl_q,
  input logic              stop_q,
  input logic              swallow_q
);
  logic adv;
  logic at_end;
  assign adv    = tick && !stop_q && !swallow_q && !wr_en;
  assign at_end = cal_q.year == 8'h99 && cal_q.mon == 5'h12 && cal_q.day == 6'h31 &&
                  cal_q.hour == 6'h23 && cal_q.min == 7'h59 && cal_q.sec == 7'h59;

  p_vl_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(2)) |=> !vl_q);

  p_vl_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    !vl_q |=> !vl_q);

  p_stop_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    (stop_q && !wr_en) |=> $stable(cal_q));

  p_discard_r10: assert property (@(posedge clk) disable iff (rst)
    (tick && swallow_q && !wr_en) |=> $stable(cal_q));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_en) |=> $stable(cal_q));

  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (adv && cal_q.sec == 7'h59) |=> cal_q.sec == 7'h00);

  p_century_r7: assert property (@(posedge clk) disable iff (rst)
    (adv && at_end) |=> (cal_q.cent != $past(cal_q.cent) && cal_q.year == 8'h00));

  p_write_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(3)) |=> cal_q.min == $past(wd_low));
endmodule

bind bcd_cal_core cal_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .wr_en     (wr_en),
  .addr      (addr),
  .wd_low    (wdata[6:0]),
  .cal_q     (cal_q),
  .vl_q      (vl_q),
  .stop_q    (stop_q),
  .swallow_q (swallow_q)
);

// File: tb/tb_bcd_cal_core.sv
module tb_bcd_cal_core;
  localparam int ADDR_W = 4;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  always #2 clk = ~clk;

  bcd_cal_core #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench-side calendar model in binary
  int m_sec, m_min, m_hour, m_day, m_wday, m_mon, m_year, m_cent;
  bit m_vl, m_stop, m_swallow;

  function automatic int to_bcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int mlen(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic m_step();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hour++;
        if (m_hour == 24) begin
          m_hour = 0; m_wday = (m_wday + 1) % 7; m_day++;
          if (m_day > mlen(m_mon, m_year)) begin
            m_day = 1; m_mon++;
            if (m_mon == 13) begin
              m_mon = 1; m_year++;
              if (m_year == 100) begin m_year = 0; m_cent ^= 1; end
            end
          end
        end
      end
    end
  endtask

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      0: begin
        if (m_stop && d[5] == 1'b0) m_swallow = 1;
        m_stop = d[5];
      end
      2: begin m_sec = (d & 15) + 10 * ((d >> 4) & 7); m_vl = 0; end
      3: m_min = (d & 15) + 10 * ((d >> 4) & 7);
      4: m_hour = (d & 15) + 10 * ((d >> 4) & 3);
      5: m_day = (d & 15) + 10 * ((d >> 4) & 3);
      6: m_wday = d & 7;
      7: begin m_mon = (d & 15) + 10 * ((d >> 4) & 1); m_cent = (d >> 7) & 1; end
      8: m_year = (d & 15) + 10 * ((d >> 4) & 15);
      default: ;
    endcase
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    addr = ADDR_W'(a);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic pulse();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    if (!m_stop) begin
      if (m_swallow) m_swallow = 0;
      else m_step();
    end
  endtask

  task automatic check_all(input string tag);
    int d;
    rd(2, d); check(tag, d, (int'(m_vl) << 7) | to_bcd(m_sec));
    rd(3, d); check(tag, d, to_bcd(m_min));
    rd(4, d); check(tag, d, to_bcd(m_hour));
    rd(5, d); check(tag, d, to_bcd(m_day));
    rd(6, d); check(tag, d, m_wday);
    rd(7, d); check(tag, d, (m_cent << 7) | to_bcd(m_mon));
    rd(8, d); check(tag, d, to_bcd(m_year));
  endtask

  task automatic load(input int s, input int mi, input int h, input int dy,
                      input int w, input int mo, input int y, input int c);
    wr(0, 8'h20);
    wr(2, to_bcd(s)); wr(3, to_bcd(mi)); wr(4, to_bcd(h)); wr(5, to_bcd(dy));
    wr(6, w); wr(7, (c << 7) | to_bcd(mo)); wr(8, to_bcd(y));
    wr(0, 8'h00);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int d;
    void'($urandom(32'd20240517));
    m_sec = 0; m_min = 0; m_hour = 0; m_day = 1; m_wday = 0; m_mon = 1;
    m_year = 0; m_cent = 0; m_vl = 1; m_stop = 0; m_swallow = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset values, R8 flag set at reset
    check_all("R12");
    rd(0, d); check("R12", d, 8'h00);
    rd(1, d); check("R12", d, 8'h00);
    rd(2, d); check("R8", d, 8'h80);

    // R1 unused address, R13 control B storage
    rd(15, d); check("R1", d, 8'h00);
    wr(1, 8'h5A); rd(1, d); check("R13", d, 8'h5A);
    wr(1, 8'hA5); rd(1, d); check("R13", d, 8'hA5);

    // R2 control A masking, R9 stop freezes
    wr(0, 8'hFF); rd(0, d); check("R2", d, 8'h20);
    pulse(); pulse();
    check_all("R9");
    // R2 unused bits read 0
    wr(3, 8'hFF); rd(3, d); check("R2", d, 8'h7F);
    wr(6, 8'hFF); rd(6, d); check("R2", d, 8'h07);
    wr(3, 8'h00); wr(6, 8'h00);
    // R8 other writes keep flag
    rd(2, d); check("R8", d, 8'h80);

    // R10 first tick after release discarded
    wr(0, 8'h00);
    pulse(); rd(2, d); check("R10", d, 8'h80);
    pulse(); rd(2, d); check("R10", d, 8'h81);
    // R8 writing seconds clears flag
    wr(2, 8'h30); rd(2, d); check("R8", d, 8'h30);

    // R7 R6 R3 full rollover at end of year 99
    load(59, 59, 23, 31, 6, 12, 99, 0);
    pulse(); pulse(); check_all("R7");
    rd(7, d); check("R7", d, 8'h81);
    rd(6, d); check("R6", d, 0);

    // R5 leap and common February
    load(59, 59, 23, 28, 2, 2, 24, 0);
    pulse(); pulse(); rd(5, d); check("R5", d, 8'h29);
    load(59, 59, 23, 28, 2, 2, 23, 0);
    pulse(); pulse(); rd(5, d); check("R5", d, 8'h01);
    rd(7, d); check("R5", d, 8'h03);
    // R4 month lengths
    load(59, 59, 23, 30, 3, 4, 10, 0);
    pulse(); pulse(); check_all("R4");
    load(59, 59, 23, 30, 3, 1, 10, 0);
    pulse(); pulse(); rd(5, d); check("R4", d, 8'h31);

    // R11 write in tick cycle wins, no advance
    load(10, 20, 5, 5, 1, 5, 5, 0);
    pulse();
    @(negedge clk);
    wr_en = 1'b1; tick = 1'b1; addr = ADDR_W'(3); wdata = 8'h44;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; m_min = 44;
    check_all("R11");

    // random starts near carry points, R3 R4 R5 R6 R7
    for (int it = 0; it < 60; it++) begin
      int s, mi, h, dy, w, mo, y, c, n;
      mo = 1 + $urandom % 12;
      y  = $urandom % 100;
      c  = $urandom % 2;
      s  = ($urandom % 3 == 0) ? 59 - $urandom % 3 : $urandom % 60;
      mi = ($urandom % 2 == 0) ? 59 : $urandom % 60;
      h  = ($urandom % 2 == 0) ? 23 : $urandom % 24;
      dy = ($urandom % 2 == 0) ? mlen(mo, y) : 1 + $urandom % mlen(mo, y);
      w  = $urandom % 7;
      n  = 1 + $urandom % 150;
      load(s, mi, h, dy, w, mo, y, c);
      for (int k = 0; k < n; k++) pulse();
      check_all("R3 R4 R5 R6 R7");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule